// File: doc/BRIEF.md
# Four-Channel Descriptor Command Sequencer

This block is the control front end of a co-processor with several command channels. Software programs it over a 32-bit register bus. Each channel holds a command pointer, a counting semaphore and an error status. Software hands work to a channel by adding to its semaphore. An enabled channel with pending work reads a seven-word descriptor from memory through a one-word-at-a-time read port. The descriptor's fields go to a processing stage, which is modelled here as a fixed number of cycles per byte. When the processing ends, the descriptor's own control bits decide whether the semaphore is decremented and whether the channel raises its interrupt flag. A nonzero link word then moves the channel on to the next descriptor.

Only one descriptor is in flight at a time. The engine re-arbitrates after every descriptor, and the lowest-numbered ready channel wins. A failed memory read parks the channel with an error code until software clears it. A second register provides one-shot clears for the interrupt flags, and each channel has its own clear register for its status.

Top module: `desc_seq`

## Requirements
- R1: After reset the interrupt flags, the enable byte, the context word, every command pointer, semaphore and channel status read zero. The memory request, the processing indication and `irq` are low.
- R2: Address 0x040 always reads 0x0005_0001, and writes to it have no effect.
- R3: A write to a channel's semaphore register (0x110 + n*0x40) adds the written value to the count. The count saturates at 2^SEMA_W-1 and reads back at the same address. The command pointer is at 0x100 + n*0x40.
- R4: A channel is ready when its enable bit is set, its command pointer has been written, its semaphore is nonzero and its status is zero. When it is served, seven words are read at ascending word addresses starting at the command pointer. The words are, in order: link, control0, control1, source, destination, byte size, payload. Each request holds its address until `mem_rvalid`.
- R5: After the seventh word, `job_active` stays high for size*CYC_PER_BYTE cycles, and for at least one cycle. During that time it presents the channel number and the descriptor fields.
- R6: On completion, control0 bit 1 decrements the channel's semaphore and control0 bit 0 sets the channel's flag, bit n of 0x010. `irq` is the OR of the flags.
- R7: On completion, a nonzero link word is loaded into the command pointer, and the channel fetches again if its semaphore is still nonzero. A zero link word makes the channel stop fetching until its command pointer is written again.
- R8: The low byte of 0x020 holds the channel enable bits. A channel whose bit is clear never fetches.
- R9: A read error sets the channel status at 0x120 + n*0x40 to 1 and sets the channel's flag. The semaphore is left unchanged. The channel fetches nothing until bit 0 is written as 1 to 0x128 + n*0x40, after which it starts again from its command pointer.
- R10: Writing ones to 0x018 clears the matching flag bits.
- R11: When several channels are ready, the lowest-numbered one is served first. A channel is served from its fetch through to its completion before the next arbitration.
- R12: A semaphore write in the completion cycle gives the sum of both changes. A flag set by the engine in the same cycle as a host clear of that flag stays set.
- R13: The context word at 0x050 is read and written as a plain 32-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hb_we | input | 1 | Register write strobe |
| hb_addr | input | 12 | Register byte address |
| hb_wdata | input | 32 | Register write data |
| hb_rdata | output | 32 | Register read data, combinational on hb_addr |
| mem_req | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_err | input | 1 | Read response carries an error |
| mem_rdata | input | 32 | Read response data |
| job_active | output | 1 | Processing stage busy with a descriptor |
| job_chan | output | 2 | Channel being processed |
| job_ctrl0 | output | 32 | Descriptor control word 0 |
| job_ctrl1 | output | 32 | Descriptor control word 1 |
| job_src | output | 32 | Descriptor source address |
| job_dst | output | 32 | Descriptor destination address |
| job_size | output | 32 | Descriptor byte count |
| job_payload | output | 32 | Descriptor payload address |
| irq | output | 1 | OR of the channel interrupt flags |

## Verification
Two things can land in the cycle in which a descriptor finishes: a host write to the same channel's semaphore, and a host clear of the flag the finishing descriptor sets. The bench runs a descriptor whose link points back to itself. It waits at a falling edge until its model shows one processing cycle left, then drives the semaphore write, and on a later pass the flag clear, into exactly that cycle. The bench reads back the result: the semaphore must equal the old count plus the write minus one, and the flag must still be set. The model is checked against the design on every clock throughout.

// File: rtl/desc_seq.sv
module desc_seq #(
  parameter int NCH = 4,
  parameter int SEMA_W = 8,
  parameter int CYC_PER_BYTE = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hb_we,
  input  logic [11:0]   hb_addr,
  input  logic [31:0]   hb_wdata,
  output logic [31:0]   hb_rdata,
  output logic          mem_req,
  output logic [31:0]   mem_addr,
  input  logic          mem_rvalid,
  input  logic          mem_err,
  input  logic [31:0]   mem_rdata,
  output logic          job_active,
  output logic [CW-1:0] job_chan,
  output logic [31:0]   job_ctrl0,
  output logic [31:0]   job_ctrl1,
  output logic [31:0]   job_src,
  output logic [31:0]   job_dst,
  output logic [31:0]   job_size,
  output logic [31:0]   job_payload,
  output logic          irq
);
  localparam logic [31:0] CAP_VAL = 32'h0005_0001;
  localparam logic [32:0] SMAX = 33'((64'd1 << SEMA_W) - 64'd1);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC} st_e;

  st_e st;
  logic [CW-1:0] cur, pick;
  logic [2:0]    widx;
  logic [31:0]   fbase, cnt, prod;
  logic [31:0]   dsc [8];

  logic [NCH-1:0][31:0]       cmdptr, cmd_nx;
  logic [NCH-1:0][SEMA_W-1:0] sema, sema_nx;
  logic [NCH-1:0] cerr, cerr_nx, armed, arm_nx, flag, flag_nx, ready;
  logic [7:0]  en;
  logic [31:0] ctx;

  logic [5:0] hchn, hoff;
  logic ch_hit, done, fbad, clr_g;

  assign hchn   = 6'((hb_addr - 12'h100) >> 6);
  assign hoff   = hb_addr[5:0];
  assign ch_hit = (hb_addr[11:8] != 4'h0) && (hchn < 6'(NCH));
  assign done   = (st == S_EXEC) && (cnt <= 32'd1);
  assign fbad   = (st == S_FETCH) && mem_rvalid && mem_err;
  assign clr_g  = hb_we && (hb_addr == 12'h018);
  assign prod   = dsc[5] * 32'(CYC_PER_BYTE);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic mine, hsel, w_cmd, w_sem, w_clr, dec, fin, set;
    logic [32:0] ssum;
    assign mine  = (cur == CW'(g));
    assign hsel  = hb_we && ch_hit && (hchn == 6'(g));
    assign w_cmd = hsel && (hoff == 6'h00);
    assign w_sem = hsel && (hoff == 6'h10);
    assign w_clr = hsel && (hoff == 6'h28);
    assign fin   = done && mine;
    assign dec   = fin && dsc[1][1];
    assign set   = (fin && dsc[1][0]) || (fbad && mine);
    assign ssum  = 33'(sema[g]) + (w_sem ? {1'b0, hb_wdata} : 33'd0) - {32'd0, dec};
    assign sema_nx[g] = (ssum > SMAX) ? '1 : ssum[SEMA_W-1:0];
    assign cerr_nx[g] = (fbad && mine) || (cerr[g] && !(w_clr && hb_wdata[0]));
    assign flag_nx[g] = set || (flag[g] && !(clr_g && hb_wdata[g]));
    assign cmd_nx[g]  = w_cmd ? hb_wdata : (fin && dsc[0] != '0) ? dsc[0] : cmdptr[g];
    assign arm_nx[g]  = w_cmd || (armed[g] && !(fin && dsc[0] == '0));
    assign ready[g]   = en[g] && armed[g] && (sema[g] != '0) && !cerr[g];
  end

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (ready[i]) pick = CW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdptr <= '0;
      sema   <= '0;
      cerr   <= '0;
      armed  <= '0;
      flag   <= '0;
      en     <= '0;
      ctx    <= '0;
    end else begin
      cmdptr <= cmd_nx;
      sema   <= sema_nx;
      cerr   <= cerr_nx;
      armed  <= arm_nx;
      flag   <= flag_nx;
      if (hb_we && hb_addr == 12'h020) en  <= hb_wdata[7:0];
      if (hb_we && hb_addr == 12'h050) ctx <= hb_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cur   <= '0;
      widx  <= '0;
      fbase <= '0;
      cnt   <= '0;
      for (int i = 0; i < 8; i++) dsc[i] <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (|ready) begin
            cur   <= pick;
            fbase <= cmdptr[pick];
            widx  <= '0;
            st    <= S_FETCH;
          end
        S_FETCH:
          if (mem_rvalid) begin
            if (mem_err) st <= S_IDLE;
            else begin
              dsc[widx] <= mem_rdata;
              if (widx == 3'd6) begin
                cnt <= (prod == '0) ? 32'd1 : prod;
                st  <= S_EXEC;
              end else widx <= widx + 3'd1;
            end
          end
        S_EXEC:
          if (cnt <= 32'd1) st <= S_IDLE;
          else cnt <= cnt - 32'd1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req     = (st == S_FETCH);
  assign mem_addr    = fbase + {27'd0, widx, 2'b00};
  assign job_active  = (st == S_EXEC);
  assign job_chan    = cur;
  assign job_ctrl0   = dsc[1];
  assign job_ctrl1   = dsc[2];
  assign job_src     = dsc[3];
  assign job_dst     = dsc[4];
  assign job_size    = dsc[5];
  assign job_payload = dsc[6];
  assign irq         = |flag;

  always_comb begin
    hb_rdata = '0;
    if (ch_hit) begin
      case (hoff)
        6'h00:   hb_rdata = cmdptr[hchn[CW-1:0]];
        6'h10:   hb_rdata = 32'(sema[hchn[CW-1:0]]);
        6'h20:   hb_rdata = 32'(cerr[hchn[CW-1:0]]);
        default: hb_rdata = '0;
      endcase
    end else begin
      case (hb_addr)
        12'h010: hb_rdata = 32'(flag);
        12'h020: hb_rdata = {24'd0, en};
        12'h040: hb_rdata = CAP_VAL;
        12'h050: hb_rdata = ctx;
        default: hb_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/desc_seq_chk.sv
module desc_seq_chk #(
  parameter int NCH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        hb_we,
  input logic [11:0] hb_addr,
  input logic [31:0] hb_wdata,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        mem_err,
  input logic        job_active,
  input logic        irq
);
  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && !mem_err) |=> (!mem_req || (mem_addr == $past(mem_addr) + 32'd4)));

  p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid && mem_err) |=> (irq && !mem_req));

  p_exec_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(job_active) |-> !mem_req);

  p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hb_we && hb_addr == 12'h018 && (&hb_wdata[NCH-1:0]) && !mem_req && !job_active) |=> !irq);

  p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && job_active));
endmodule

bind desc_seq desc_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_err(mem_err),
  .job_active(job_active), .irq(irq)
);

// File: tb/sim_desc_seq.sv
`timescale 1ns/1ps
module sim_desc_seq;
  localparam int CPB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hb_we = 1'b0;
  logic [11:0] hb_addr = '0;
  logic [31:0] hb_wdata = '0;
  logic [31:0] hb_rdata;
  logic mem_req;
  logic [31:0] mem_addr;
  logic mem_rvalid = 1'b0;
  logic mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic job_active;
  logic [1:0] job_chan;
  logic [31:0] job_ctrl0, job_ctrl1, job_src, job_dst, job_size, job_payload;
  logic irq;

  always #4 clk = ~clk;

  desc_seq u0 (
    .clk(clk), .rst_n(rst_n), .hb_we(hb_we), .hb_addr(hb_addr), .hb_wdata(hb_wdata),
    .hb_rdata(hb_rdata), .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .job_active(job_active), .job_chan(job_chan),
    .job_ctrl0(job_ctrl0), .job_ctrl1(job_ctrl1), .job_src(job_src), .job_dst(job_dst),
    .job_size(job_size), .job_payload(job_payload), .irq(irq)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Memory: word array, two-cycle response, one address may be marked bad
  logic [31:0] memw [256];
  logic [31:0] bad_addr = 32'hFFFF_FFFF;
  int wc = 0;
  int req_cycles = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_rvalid = 1'b0; mem_err = 1'b0; wc = 0;
    end else if (mem_rvalid) begin
      mem_rvalid = 1'b0; mem_err = 1'b0;
    end else if (mem_req) begin
      wc++;
      if (wc >= 2) begin
        wc = 0;
        mem_rvalid = 1'b1;
        mem_rdata = memw[mem_addr[9:2]];
        mem_err = (mem_addr == bad_addr);
      end
    end
  end

  // Behavioural reference model
  logic [31:0] m_cmd [4];
  int          m_sema [4];
  bit          m_err [4], m_arm [4], m_flag [4];
  logic [7:0]  m_en = '0;
  logic [31:0] m_ctx = '0;
  int          m_st = 0, m_cur = 0, m_idx = 0;
  logic [31:0] m_base = '0, m_cnt = '0;
  logic [31:0] m_d [7];

  initial begin
    for (int n = 0; n < 4; n++) begin
      m_cmd[n] = '0; m_sema[n] = 0; m_err[n] = 0; m_arm[n] = 0; m_flag[n] = 0;
    end
    for (int i = 0; i < 7; i++) m_d[i] = '0;
    for (int i = 0; i < 256; i++) memw[i] = '0;
  end

  always @(posedge clk) begin
    bit done, bad;
    int pk;
    logic [31:0] pbase;
    logic [11:0] ba;
    longint s;
    if (!rst_n) begin
      for (int n = 0; n < 4; n++) begin
        m_cmd[n] = '0; m_sema[n] = 0; m_err[n] = 0; m_arm[n] = 0; m_flag[n] = 0;
      end
      m_en = '0; m_ctx = '0; m_st = 0; m_cur = 0; m_idx = 0; m_base = '0; m_cnt = '0;
    end else begin
      done = (m_st == 2) && (m_cnt <= 1);
      bad  = (m_st == 1) && mem_rvalid && mem_err;
      pk = -1;
      pbase = '0;
      for (int n = 3; n >= 0; n--)
        if (m_en[n] && m_arm[n] && m_sema[n] != 0 && !m_err[n]) pk = n;
      if (pk >= 0) pbase = m_cmd[pk];
      for (int n = 0; n < 4; n++) begin
        ba = 12'(12'h100 + n * 64);
        s = m_sema[n];
        if (hb_we && hb_addr == ba + 12'h010) s = s + longint'(hb_wdata);
        if (done && m_cur == n && m_d[1][1]) s = s - 1;
        if (s > 255) s = 255;
        m_sema[n] = int'(s);
        if (bad && m_cur == n) m_err[n] = 1;
        else if (hb_we && hb_addr == ba + 12'h028 && hb_wdata[0]) m_err[n] = 0;
        if ((done && m_cur == n && m_d[1][0]) || (bad && m_cur == n)) m_flag[n] = 1;
        else if (hb_we && hb_addr == 12'h018 && hb_wdata[n]) m_flag[n] = 0;
        if (hb_we && hb_addr == ba) begin
          m_cmd[n] = hb_wdata; m_arm[n] = 1;
        end else if (done && m_cur == n) begin
          if (m_d[0] != 0) m_cmd[n] = m_d[0];
          else m_arm[n] = 0;
        end
      end
      if (hb_we && hb_addr == 12'h020) m_en = hb_wdata[7:0];
      if (hb_we && hb_addr == 12'h050) m_ctx = hb_wdata;
      if (m_st == 0) begin
        if (pk >= 0) begin m_cur = pk; m_base = pbase; m_idx = 0; m_st = 1; end
      end else if (m_st == 1) begin
        if (mem_rvalid) begin
          if (mem_err) m_st = 0;
          else begin
            m_d[m_idx] = mem_rdata;
            if (m_idx == 6) begin
              m_cnt = m_d[5] * CPB;
              if (m_cnt == 0) m_cnt = 1;
              m_st = 2;
            end else m_idx++;
          end
        end
      end else begin
        if (m_cnt <= 1) m_st = 0;
        else m_cnt = m_cnt - 1;
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [11:0] a);
    for (int n = 0; n < 4; n++) begin
      if (a == 12'(12'h100 + n * 64)) return m_cmd[n];
      if (a == 12'(12'h110 + n * 64)) return 32'(m_sema[n]);
      if (a == 12'(12'h120 + n * 64)) return 32'(m_err[n]);
    end
    case (a)
      12'h010: return {28'd0, m_flag[3], m_flag[2], m_flag[1], m_flag[0]};
      12'h020: return {24'd0, m_en};
      12'h040: return 32'h0005_0001;
      12'h050: return m_ctx;
      default: return '0;
    endcase
  endfunction

  // Per-clock comparison and run-length monitor
  int run = 0;
  int lens [8];
  int lens_n = 0;

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      chk(mem_req === (m_st == 1), "R4", "mem_req", 32'(mem_req), 32'(m_st == 1));
      if (m_st == 1)
        chk(mem_addr === m_base + 32'(m_idx * 4), "R4", "mem_addr", mem_addr, m_base + 32'(m_idx * 4));
      chk(job_active === (m_st == 2), "R5", "job_active", 32'(job_active), 32'(m_st == 2));
      if (m_st == 2 && job_active) begin
        chk(job_chan === 2'(m_cur), "R11", "job_chan", 32'(job_chan), 32'(m_cur));
        chk(job_ctrl0 === m_d[1] && job_size === m_d[5] && job_src === m_d[3], "R5",
            "job fields", job_src, m_d[3]);
      end
      chk(irq === (m_flag[0] | m_flag[1] | m_flag[2] | m_flag[3]), "R6", "irq",
          32'(irq), 32'(m_flag[0] | m_flag[1] | m_flag[2] | m_flag[3]));
      if (mem_req) req_cycles++;
      if (job_active) run++;
      else if (run > 0) begin
        if (lens_n < 8) lens[lens_n] = run;
        lens_n++;
        run = 0;
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    hb_we = 1'b1; hb_addr = a; hb_wdata = d;
    @(negedge clk);
    hb_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    logic [31:0] e;
    @(negedge clk);
    hb_addr = a;
    #1;
    e = m_read(a);
    chk(hb_rdata === e, tag, $sformatf("read %h", a), hb_rdata, e);
  endtask

  task automatic rdx(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    hb_addr = a;
    #1;
    chk(hb_rdata === e, tag, $sformatf("read %h", a), hb_rdata, e);
  endtask

  task automatic put_desc(input int a, input logic [31:0] nx, input logic [31:0] c0,
                          input logic [31:0] sz, input logic [31:0] src);
    memw[a/4 + 0] = nx;
    memw[a/4 + 1] = c0;
    memw[a/4 + 2] = 32'h0000_0010;
    memw[a/4 + 3] = src;
    memw[a/4 + 4] = src + 32'h1000;
    memw[a/4 + 5] = sz;
    memw[a/4 + 6] = 32'h0000_0500;
  endtask

  task automatic wait_last_cycle();
    forever begin
      @(negedge clk);
      if (m_st == 2 && m_cnt == 1) break;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    put_desc(32'h40, 32'h80, 32'h3, 32'd3, 32'h1000);
    put_desc(32'h80, 32'h0, 32'h3, 32'd0, 32'h1100);
    put_desc(32'hC0, 32'h0, 32'h1, 32'd1, 32'h1200);
    put_desc(32'h100, 32'h0, 32'h2, 32'd2, 32'h1300);
    put_desc(32'h200, 32'h0, 32'h3, 32'd1, 32'h1400);
    put_desc(32'h300, 32'h300, 32'h3, 32'd10, 32'h1500);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rdx(12'h010, 32'h0, "R1");
    rdx(12'h020, 32'h0, "R1");
    rdx(12'h050, 32'h0, "R1");
    rdx(12'h100, 32'h0, "R1");
    rdx(12'h110, 32'h0, "R1");
    rdx(12'h1E0, 32'h0, "R1");
    chk(mem_req === 1'b0 && irq === 1'b0, "R1", "idle outputs", {30'd0, mem_req, irq}, 32'h0);

    // R2 capability
    rdx(12'h040, 32'h0005_0001, "R2");
    wr(12'h040, 32'hDEAD_BEEF);
    rdx(12'h040, 32'h0005_0001, "R2");

    // R13 context word
    wr(12'h050, 32'hFFFF_0000);
    rdx(12'h050, 32'hFFFF_0000, "R13");

    // R3 / R8: work queued on a disabled channel
    wr(12'h100, 32'h40);
    wr(12'h110, 32'd2);
    wr(12'h110, 32'd1);
    rdx(12'h110, 32'd3, "R3");
    repeat (20) @(negedge clk);
    chk(req_cycles == 0, "R8", "fetch while disabled", 32'(req_cycles), 32'h0);

    // R4 R5 R6 R7: two-descriptor chain on channel 0
    wr(12'h020, 32'h01);
    repeat (120) @(negedge clk);
    rdx(12'h110, 32'd1, "R7");
    rdx(12'h100, 32'h80, "R7");
    rdx(12'h010, 32'h1, "R6");
    chk(lens_n == 2 && lens[0] == 3 * CPB, "R5", "first job length", 32'(lens[0]), 32'(3 * CPB));
    chk(lens[1] == 1, "R5", "zero-size job length", 32'(lens[1]), 32'd1);
    chk(mem_req === 1'b0, "R7", "stopped after zero link", 32'(mem_req), 32'h0);

    // R10 global flag clear
    wr(12'h018, 32'h1);
    rdx(12'h010, 32'h0, "R10");
    chk(irq === 1'b0, "R10", "irq after clear", 32'(irq), 32'h0);

    // R3 saturation on channel 1 (never armed)
    wr(12'h150, 32'h1FF);
    rdx(12'h150, 32'd255, "R3");

    // R11 priority between channels 2 and 3
    wr(12'h180, 32'hC0);
    wr(12'h190, 32'd1);
    wr(12'h1C0, 32'h100);
    wr(12'h1D0, 32'd1);
    wr(12'h020, 32'h0F);
    forever begin
      @(negedge clk);
      if (mem_req) break;
    end
    chk(mem_addr === 32'hC0, "R11", "first fetch address", mem_addr, 32'hC0);
    repeat (120) @(negedge clk);
    rdx(12'h190, 32'd1, "R6");
    rdx(12'h1D0, 32'd0, "R6");
    rdx(12'h010, 32'h4, "R6");
    rd(12'h150, "R8");

    // R9 read error on channel 0
    bad_addr = 32'h208;
    wr(12'h100, 32'h200);
    repeat (40) @(negedge clk);
    rdx(12'h120, 32'd1, "R9");
    rdx(12'h110, 32'd1, "R9");
    rdx(12'h010, 32'h5, "R9");
    chk(mem_req === 1'b0, "R9", "stalled after error", 32'(mem_req), 32'h0);
    bad_addr = 32'hFFFF_FFFF;
    wr(12'h128, 32'h1);
    repeat (60) @(negedge clk);
    rdx(12'h120, 32'd0, "R9");
    rdx(12'h110, 32'd0, "R9");
    rd(12'h100, "R9");

    // R12 same-cycle collisions on a self-linked descriptor
    wr(12'h018, 32'hF);
    wr(12'h100, 32'h300);
    wr(12'h110, 32'd1);
    wait_last_cycle();
    hb_we = 1'b1; hb_addr = 12'h110; hb_wdata = 32'd2;
    @(negedge clk);
    hb_we = 1'b0;
    rdx(12'h110, 32'd2, "R12");
    wr(12'h018, 32'hF);
    wait_last_cycle();
    hb_we = 1'b1; hb_addr = 12'h018; hb_wdata = 32'h1;
    @(negedge clk);
    hb_we = 1'b0;
    rdx(12'h010, 32'h1, "R12");
    repeat (150) @(negedge clk);
    rdx(12'h110, 32'd0, "R7");
    chk(mem_req === 1'b0 && job_active === 1'b0, "R7", "quiet after count drained",
        {30'd0, mem_req, job_active}, 32'h0);
    rd(12'h010, "R10");
    rd(12'h020, "R8");

    finish_run();
  end
endmodule